// File: doc/BRIEF.md
# Hot-Swap Startup and Fault Sequencer

This block is the digital control core of a two-rail hot-swap controller. Its inputs are already digitised: an undervoltage-OK flag for each rail, an ON enable level, the slow and fast overcurrent comparator outputs, and a selector that chooses between latched and automatic-retry fault handling. From these it drives the enable of the external pass-transistor gates, a flag that puts the fast comparator into current-limit duty while the gates are coming up, a request for a strong gate discharge, a fault flag and a power-good level.

All timing is counted in ticks of a one-microsecond enable strobe, `tick_us`. The lockout delay, the startup length, the clear qualifier and the retry multiplier are parameters. A run has these phases. First, a lockout delay that begins once at least one rail is good. Next comes a startup phase. In startup the slow comparator is masked, and the fast comparator throttles the gate instead of tripping a fault. After startup comes normal operation, where either comparator trips a fault. A fault then ends in one of two ways, depending on the mode selector. In latched mode the block waits for a qualified clear. In retry mode it waits a long back-off and then restarts on its own.

Top module: `hsw_sequencer`

## Requirements
- R1: The gates stay off until at least one of `rail_a_ok`/`rail_b_ok` has been true without a gap for `T_UVLO` ticks.
- R2: Once the lockout delay has elapsed and `on_req` is high, startup begins: `su_limit` = 1, `gate_en` = 1, `pwr_good` = 0.
- R3: During startup, `oc_slow` is ignored and never raises `fault_flag`.
- R4: During startup, `oc_fast` = 1 forces `gate_en` to 0 in the same cycle, without a fault. `su_limit` stays 1.
- R5: Startup lasts `T_START` ticks. After that, `pwr_good` = 1, `su_limit` = 0 and `gate_en` = 1.
- R6: In normal operation, `oc_slow` or `oc_fast` high causes the following from the next cycle: `fault_flag` = 1, `gate_pulldown` = 1, `gate_en` = 0 and `pwr_good` = 0.
- R7: With `mode_retry` = 0 at the fault, the fault holds. It clears only when `on_req` stays low, or when a rail stays not-OK, for `T_CLEAR` consecutive ticks. A shorter episode has no effect. After the clear, startup resumes once ON and lockout allow it.
- R8: With `mode_retry` = 1 at the fault, the block restarts startup by itself after `T_START*RETRY_MULT` ticks (64 × startup by default).
- R9: During the retry wait, `on_req` low, however long, neither clears the fault nor shortens the wait.
- R10: During the retry wait, either rail flag going low for even one cycle ends the wait. The block re-enters startup within two cycles, provided the other rail kept the lockout satisfied.
- R11: Both rail flags low together, in startup or in normal operation, turn the gates off. The full lockout delay then applies again before startup.
- R12: `on_req` low with no fault held turns the gates off, with no fault. Startup repeats when ON rises.
- R13: An overcurrent and both rails dropping in the same normal-operation cycle produce a fault (the fault takes priority).
- R14: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| rail_a_ok | input | 1 | Rail A above undervoltage threshold |
| rail_b_ok | input | 1 | Rail B above undervoltage threshold |
| on_req | input | 1 | ON enable level |
| oc_slow | input | 1 | Slow overcurrent comparator output |
| oc_fast | input | 1 | Fast overcurrent comparator output |
| mode_retry | input | 1 | 1 = automatic retry, 0 = latched fault |
| gate_en | output | 1 | Gate drive enable |
| su_limit | output | 1 | Startup current-limit mode for fast comparator |
| gate_pulldown | output | 1 | Strong gate discharge request |
| fault_flag | output | 1 | Fault held |
| pwr_good | output | 1 | Normal operation reached |

## Verification
Two events can land in the same cycle of normal operation: an overcurrent trip and the collapse of both rails. The bench raises `oc_fast` and drops both rail flags on the same clock. It judges the result by whether `fault_flag` is set one cycle later, rather than the block falling back to an idle state that would only re-run the lockout. A second overlap is probed during the retry wait: ON is held low past the clear qualifier, and the check confirms that only the back-off timer or a rail dip releases the fault.

// File: rtl/hsw_pkg.sv
// Package: shared state encoding for the hot-swap sequencer.
// Assumes: consumers only compare against these names, never raw codes.
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // gates off, waiting for lockout and ON
        ST_START  = 3'd1,  // gates ramping, fast comparator limits
        ST_RUN    = 3'd2,  // normal operation, both comparators trip
        ST_FLATCH = 3'd3,  // fault held until a qualified clear
        ST_FRETRY = 3'd4   // fault held for the retry back-off
    } hsw_state_t;

endpackage

// File: rtl/hsw_qualifier.sv
// Module: hsw_qualifier
// Reports that a condition has held without a break for LIMIT ticks.
// Assumes: tick is a single-cycle strobe; a low 'arm' or 'cond' restarts
// the count on the next edge; 'met' stays high while the condition persists.
module hsw_qualifier #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic cond,
    output logic met
);
    localparam int QW = $clog2(LIMIT + 1);
    localparam logic [QW-1:0] LIM = QW'(LIMIT);

    logic [QW-1:0] cnt_q;

    // Count ticks of an unbroken condition, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign met = (cnt_q == LIM);
endmodule

// File: rtl/hsw_tick_timer.sv
// Module: hsw_tick_timer
// Phase timer: counts microsecond ticks since the last clear, saturating.
// Assumes: the owner clears it on every state change.
module hsw_tick_timer #(
    parameter int MAXCOUNT = 512,
    parameter int CW       = $clog2(MAXCOUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(MAXCOUNT);

    logic [CW-1:0] cnt_q;

    // Restart on clear, otherwise advance once per tick up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/hsw_fsm.sv
// Module: hsw_fsm
// Phase controller: lockout wait, startup, normal run, latched or
// retry fault. Decodes the output levels from the registered state.
// Assumes: uv_ready and clr_met come from hsw_qualifier instances,
// tmr_count from hsw_tick_timer cleared via tmr_clr on each transition.
module hsw_fsm
    import hsw_pkg::*;
#(
    parameter int START_TICKS = 1000,
    parameter int RETRY_TICKS = 64000,
    parameter int CW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uv_ready,
    input  logic          any_ok,
    input  logic          any_low,
    input  logic          both_low,
    input  logic          on_req,
    input  logic          oc_slow,
    input  logic          oc_fast,
    input  logic          mode_retry,
    input  logic          clr_met,
    input  logic [CW-1:0] tmr_count,
    output hsw_state_t    state,
    output logic          tmr_clr,
    output logic          gate_en,
    output logic          su_limit,
    output logic          gate_pulldown,
    output logic          fault_flag,
    output logic          pwr_good
);
    localparam logic [CW-1:0] START_LIM = CW'(START_TICKS);
    localparam logic [CW-1:0] RETRY_LIM = CW'(RETRY_TICKS);

    hsw_state_t st_q, st_d;
    logic       oc_any;

    assign oc_any = oc_slow | oc_fast;

    // Next-state selection; an overcurrent in RUN outranks a supply collapse.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (uv_ready && any_ok && on_req) st_d = ST_START;
            end
            ST_START: begin
                if (both_low || !on_req)          st_d = ST_IDLE;
                else if (tmr_count >= START_LIM)  st_d = ST_RUN;
            end
            ST_RUN: begin
                if (oc_any)                       st_d = mode_retry ? ST_FRETRY : ST_FLATCH;
                else if (both_low || !on_req)     st_d = ST_IDLE;
            end
            ST_FLATCH: begin
                if (clr_met)                      st_d = ST_IDLE;
            end
            ST_FRETRY: begin
                if (any_low)                      st_d = ST_IDLE;
                else if (tmr_count >= RETRY_LIM)  st_d = ST_IDLE;
            end
            default:                              st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output decode; the fast comparator throttles the gate during startup.
    always_comb begin
        gate_en       = ((st_q == ST_START) && !oc_fast) || (st_q == ST_RUN);
        su_limit      = (st_q == ST_START);
        pwr_good      = (st_q == ST_RUN);
        fault_flag    = (st_q == ST_FLATCH) || (st_q == ST_FRETRY);
        gate_pulldown = fault_flag;
    end

    assign tmr_clr = (st_d != st_q);
    assign state   = st_q;
endmodule

// File: rtl/hsw_sequencer.sv
// Module: hsw_sequencer (top)
// Hot-swap startup and fault sequencer for two supply rails.
// Assumes: all inputs are synchronous to clk; tick_us pulses one cycle
// per microsecond; all delays below are counted in those ticks.
module hsw_sequencer
    import hsw_pkg::*;
#(
    parameter int T_UVLO     = 100,
    parameter int T_START    = 1000,
    parameter int T_CLEAR    = 100,
    parameter int RETRY_MULT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic rail_a_ok,
    input  logic rail_b_ok,
    input  logic on_req,
    input  logic oc_slow,
    input  logic oc_fast,
    input  logic mode_retry,
    output logic gate_en,
    output logic su_limit,
    output logic gate_pulldown,
    output logic fault_flag,
    output logic pwr_good
);
    localparam int RETRY_TICKS = T_START * RETRY_MULT;
    localparam int TMR_MAX     = (RETRY_TICKS > T_START) ? RETRY_TICKS : T_START;
    localparam int CW          = $clog2(TMR_MAX + 1);
    localparam int N_CLR       = 2;

    hsw_state_t    state;
    logic          any_ok, any_low, both_low;
    logic          uv_ready, tmr_clr, latch_armed, clr_met;
    logic [CW-1:0] tmr_count;
    logic [N_CLR-1:0] clr_cond, clr_hit;

    assign any_ok      = rail_a_ok | rail_b_ok;
    assign any_low     = !rail_a_ok | !rail_b_ok;
    assign both_low    = !any_ok;
    assign latch_armed = (state == ST_FLATCH);

    // Lockout: one rail good without a break for T_UVLO ticks.
    hsw_qualifier #(.LIMIT(T_UVLO)) u_lockout (
        .clk (clk), .rst_n (rst_n), .tick (tick_us),
        .arm (1'b1), .cond (any_ok), .met (uv_ready)
    );

    // Latched-fault clear sources: ON held low, or a rail held low.
    assign clr_cond = {any_low, !on_req};

    generate
        for (genvar g = 0; g < N_CLR; g++) begin : g_clr
            hsw_qualifier #(.LIMIT(T_CLEAR)) u_clrq (
                .clk (clk), .rst_n (rst_n), .tick (tick_us),
                .arm (latch_armed), .cond (clr_cond[g]), .met (clr_hit[g])
            );
        end
    endgenerate

    assign clr_met = |clr_hit;

    // Shared phase timer for startup length and retry back-off.
    hsw_tick_timer #(.MAXCOUNT(TMR_MAX), .CW(CW)) u_timer (
        .clk (clk), .rst_n (rst_n), .tick (tick_us),
        .clr (tmr_clr), .count (tmr_count)
    );

    hsw_fsm #(
        .START_TICKS (T_START),
        .RETRY_TICKS (RETRY_TICKS),
        .CW          (CW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .uv_ready      (uv_ready),
        .any_ok        (any_ok),
        .any_low       (any_low),
        .both_low      (both_low),
        .on_req        (on_req),
        .oc_slow       (oc_slow),
        .oc_fast       (oc_fast),
        .mode_retry    (mode_retry),
        .clr_met       (clr_met),
        .tmr_count     (tmr_count),
        .state         (state),
        .tmr_clr       (tmr_clr),
        .gate_en       (gate_en),
        .su_limit      (su_limit),
        .gate_pulldown (gate_pulldown),
        .fault_flag    (fault_flag),
        .pwr_good      (pwr_good)
    );
endmodule

// File: rtl/hsw_sequencer_chk.sv
// Module: hsw_sequencer_chk
// Temporal checks on the sequencer's ports, bound into every instance.
// Assumes: reset is synchronous and active low.
module hsw_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic rail_a_ok,
    input logic rail_b_ok,
    input logic on_req,
    input logic oc_slow,
    input logic oc_fast,
    input logic gate_en,
    input logic su_limit,
    input logic gate_pulldown,
    input logic fault_flag,
    input logic pwr_good,
    input logic uv_ready
);
    // R1: gates only run after the lockout qualifier is satisfied.
    a_r1_gate_needs_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> uv_ready);

    // R3: startup never passes directly into a fault.
    a_r3_slow_masked: assert property (@(posedge clk) disable iff (!rst_n)
        su_limit |=> !fault_flag);

    // R4: fast comparator during startup throttles without faulting.
    a_r4_fast_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (su_limit && oc_fast) |-> (!gate_en && !fault_flag));

    // R5: the phases are mutually exclusive.
    a_r5_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({su_limit, pwr_good, fault_flag}));

    // R6: an overcurrent in normal operation trips on the next cycle.
    a_r6_trip_on_oc: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && (oc_slow || oc_fast)) |=> (fault_flag && gate_pulldown && !pwr_good && !gate_en));

    // R11: both rails gone during startup shuts the gates.
    a_r11_both_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        (su_limit && !rail_a_ok && !rail_b_ok) |=> !gate_en);

    // R12: ON low in normal operation exits without a fault.
    a_r12_on_low_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !on_req && !oc_slow && !oc_fast) |=> (!pwr_good && !fault_flag));
endmodule

bind hsw_sequencer hsw_sequencer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rail_a_ok     (rail_a_ok),
    .rail_b_ok     (rail_b_ok),
    .on_req        (on_req),
    .oc_slow       (oc_slow),
    .oc_fast       (oc_fast),
    .gate_en       (gate_en),
    .su_limit      (su_limit),
    .gate_pulldown (gate_pulldown),
    .fault_flag    (fault_flag),
    .pwr_good      (pwr_good),
    .uv_ready      (uv_ready)
);

// File: tb/hsw_sequencer_test.sv
// Directed bench for hsw_sequencer: one task per scenario.
module hsw_sequencer_test;
    localparam int T_UVLO  = 5;
    localparam int T_START = 8;
    localparam int T_CLEAR = 6;
    localparam int RMUL    = 64;
    localparam int RETRY   = T_START * RMUL;
    localparam int TDIV    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic rail_a_ok = 1'b0, rail_b_ok = 1'b0, on_req = 1'b0;
    logic oc_slow = 1'b0, oc_fast = 1'b0, mode_retry = 1'b0;
    logic gate_en, su_limit, gate_pulldown, fault_flag, pwr_good;
    int   n_chk = 0, n_bad = 0;
    int   tdiv = 0;

    hsw_sequencer #(.T_UVLO(T_UVLO), .T_START(T_START), .T_CLEAR(T_CLEAR), .RETRY_MULT(RMUL)) uut (
        .clk (clk), .rst_n (rst_n), .tick_us (tick_us),
        .rail_a_ok (rail_a_ok), .rail_b_ok (rail_b_ok), .on_req (on_req),
        .oc_slow (oc_slow), .oc_fast (oc_fast), .mode_retry (mode_retry),
        .gate_en (gate_en), .su_limit (su_limit), .gate_pulldown (gate_pulldown),
        .fault_flag (fault_flag), .pwr_good (pwr_good)
    );

    always #5 clk = ~clk;

    // Microsecond strobe, one cycle in TDIV, driven away from the active edge.
    always @(negedge clk) begin
        tdiv    = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        tick_us = (tdiv == 0);
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        cyc(n * TDIV);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; rail_a_ok = 0; rail_b_ok = 0; on_req = 0;
        oc_slow = 0; oc_fast = 0; mode_retry = 0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    // Power both rails with ON and wait for normal operation.
    task automatic bring_up;
        rail_a_ok = 1; rail_b_ok = 1; on_req = 1;
        ticks(T_UVLO + T_START + 4);
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0; cyc(2);
        check("R14", "gate_en", gate_en, 1'b0);
        check("R14", "su_limit", su_limit, 1'b0);
        check("R14", "pulldown", gate_pulldown, 1'b0);
        check("R14", "fault", fault_flag, 1'b0);
        check("R14", "pwr_good", pwr_good, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_startup;
        do_reset();
        rail_a_ok = 1; on_req = 1;
        ticks(T_UVLO - 2);
        check("R1", "gate off inside lockout", gate_en, 1'b0);
        ticks(4);
        check("R2", "startup limit", su_limit, 1'b1);
        check("R2", "gate on", gate_en, 1'b1);
        check("R2", "no pwr_good", pwr_good, 1'b0);
        oc_slow = 1; ticks(2);
        check("R3", "slow ignored", fault_flag, 1'b0);
        check("R3", "still starting", su_limit, 1'b1);
        oc_slow = 0; oc_fast = 1; cyc(1);
        check("R4", "gate throttled", gate_en, 1'b0);
        check("R4", "no fault", fault_flag, 1'b0);
        check("R4", "limit kept", su_limit, 1'b1);
        oc_fast = 0; cyc(1);
        check("R4", "gate back", gate_en, 1'b1);
        ticks(T_START);
        check("R5", "pwr_good", pwr_good, 1'b1);
        check("R5", "limit off", su_limit, 1'b0);
        check("R5", "gate on", gate_en, 1'b1);
    endtask

    task automatic t_latched;
        do_reset(); bring_up();
        oc_slow = 1; cyc(1); oc_slow = 0;
        check("R6", "fault", fault_flag, 1'b1);
        check("R6", "pulldown", gate_pulldown, 1'b1);
        check("R6", "gate off", gate_en, 1'b0);
        check("R6", "pwr_good low", pwr_good, 1'b0);
        on_req = 0; ticks(T_CLEAR - 3); on_req = 1; cyc(2);
        check("R7", "short ON low keeps fault", fault_flag, 1'b1);
        on_req = 0; ticks(T_CLEAR + 2);
        check("R7", "ON clear", fault_flag, 1'b0);
        check("R7", "idle while ON low", gate_en, 1'b0);
        on_req = 1; cyc(3);
        check("R7", "restart after ON clear", su_limit, 1'b1);
        ticks(T_START + 3);
        oc_fast = 1; cyc(1); oc_fast = 0;
        check("R6", "fast trip", fault_flag, 1'b1);
        rail_b_ok = 0; ticks(T_CLEAR + 2);
        check("R7", "rail clear", fault_flag, 1'b0);
        check("R7", "restart after rail clear", su_limit, 1'b1);
        rail_b_ok = 1;
    endtask

    task automatic t_retry;
        do_reset(); bring_up();
        mode_retry = 1;
        oc_fast = 1; cyc(1); oc_fast = 0;
        check("R6", "retry-mode trip", fault_flag, 1'b1);
        on_req = 0; ticks(T_CLEAR + 4);
        check("R9", "ON low ignored", fault_flag, 1'b1);
        on_req = 1;
        ticks(RETRY - (T_CLEAR + 4) - 3);
        check("R9", "wait not shortened", fault_flag, 1'b1);
        check("R8", "still waiting", su_limit, 1'b0);
        ticks(6);
        check("R8", "auto restart", su_limit, 1'b1);
        check("R8", "fault released", fault_flag, 1'b0);
    endtask

    task automatic t_abort;
        do_reset(); bring_up();
        mode_retry = 1;
        oc_slow = 1; cyc(1); oc_slow = 0;
        check("R10", "trip", fault_flag, 1'b1);
        ticks(20);
        rail_a_ok = 0; cyc(1); rail_a_ok = 1; cyc(2);
        check("R10", "abort to startup", su_limit, 1'b1);
        check("R10", "fault released", fault_flag, 1'b0);
    endtask

    task automatic t_both_low;
        do_reset(); bring_up();
        rail_a_ok = 0; rail_b_ok = 0; cyc(1);
        rail_a_ok = 1; rail_b_ok = 1; cyc(1);
        check("R11", "gates off", gate_en, 1'b0);
        check("R11", "no fault", fault_flag, 1'b0);
        ticks(T_UVLO - 2);
        check("R11", "lockout repeats", gate_en, 1'b0);
        ticks(4);
        check("R11", "startup again", su_limit, 1'b1);
    endtask

    task automatic t_on_low;
        do_reset(); bring_up();
        on_req = 0; cyc(1);
        check("R12", "gates off", gate_en, 1'b0);
        check("R12", "no fault", fault_flag, 1'b0);
        check("R12", "pwr_good low", pwr_good, 1'b0);
        ticks(10);
        check("R12", "stays off", gate_en, 1'b0);
        on_req = 1; cyc(3);
        check("R12", "startup on ON", su_limit, 1'b1);
    endtask

    task automatic t_same_cycle;
        do_reset(); bring_up();
        oc_fast = 1; rail_a_ok = 0; rail_b_ok = 0; cyc(1);
        oc_fast = 0;
        check("R13", "fault wins", fault_flag, 1'b1);
        check("R13", "pulldown", gate_pulldown, 1'b1);
        rail_a_ok = 1; rail_b_ok = 1;
    endtask

    initial begin
        #(10 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        cyc(2);
        t_reset();
        t_startup();
        t_latched();
        t_retry();
        t_abort();
        t_both_low();
        t_on_low();
        t_same_cycle();
        summary();
    end
endmodule